// File: doc/BRIEF.md
# Presettable Synchronous Up-Counter with Cascade Enables

This block is a binary up-counter of parameterised width (four bits by default). It can be cleared, preset in parallel from a data bus, counted up, or held. Every state bit changes on the rising clock edge, with one exception: when the `ASYNC_CLEAR` parameter is set, the active-low clear acts at once and does not wait for the clock. When that parameter is zero, clear takes effect at the next rising edge. The load input is active low and synchronous. While load is asserted, the two count enables are ignored.

The counter has two count enables, `step_en` and `chain_en`, and it increments only when both are high. `chain_en` also gates the carry output. `carry_out` is high when `chain_en` is high, the count is all ones and clear is not active. Because `carry_out` is decoded combinationally from the state, it drops in the same edge that wraps the count to zero. To build a wider counter, tie the `carry_out` of each stage to the `chain_en` of the next stage up. Drive `step_en` of every stage from a shared run signal.

Top module: `presettable_counter`

## Requirements
- R1: When clear_n and load_n are both high and step_en and chain_en are both high, q increases by one on each rising clock edge.
- R2: From the all-ones value (15 at the default width), a count step gives zero.
- R3: With clear_n high and load_n low, q takes par_d on the next rising edge, whatever the values of step_en and chain_en.
- R4: With clear_n and load_n high, q keeps its value across an edge if step_en is low or chain_en is low.
- R5: With ASYNC_CLEAR=1, q goes to zero as soon as clear_n goes low, before any clock edge arrives.
- R6: With ASYNC_CLEAR=0, a low clear_n leaves q unchanged until the next rising edge, and that edge sets q to zero.
- R7: Clear takes priority over load: if clear_n and load_n are both low at an edge, q is zero afterwards.
- R8: carry_out is 1 exactly when chain_en is 1, q is all ones and clear_n is 1. step_en has no effect on it, so a held all-ones count with chain_en high still shows carry.
- R9: When two stages are cascaded (the low stage's carry_out drives the high stage's chain_en, and step_en is shared), the pair counts as one 8-bit counter that wraps from 255 to 0. The low carry drops as the low stage wraps.
- R10: Load takes priority over counting: when load_n is low and both enables are high, q takes par_d and is not incremented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clear_n | input | 1 | Active-low clear. Asynchronous or synchronous, chosen by ASYNC_CLEAR |
| load_n | input | 1 | Active-low synchronous parallel load |
| par_d | input | WIDTH | Preset value |
| step_en | input | 1 | Count enable that has no effect on the carry |
| chain_en | input | 1 | Count enable that also gates carry_out |
| q | output | WIDTH | Current count |
| carry_out | output | 1 | Terminal-count carry for cascading |

## Verification
The interesting collisions are between clear and load, between load and count, and between a count step and a wrap. In the first case, clear_n and load_n are pulled low before the same edge and the expected result is a zero count. In the second, load_n is pulled low with both enables high and the expected result is the preset value with no increment. Clear timing is checked by dropping clear_n midway between edges and sampling before the next edge. At that point an asynchronous stage must already read zero and a synchronous stage must still hold its old value. The wrap of a cascaded pair is judged against an 8-bit reference count kept in the bench. The bench runs one pair built in each clear mode through more than 256 steps.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;

  typedef enum logic [1:0] {
    OP_CLEAR = 2'd0,
    OP_LOAD  = 2'd1,
    OP_COUNT = 2'd2,
    OP_HOLD  = 2'd3
  } pcnt_op_e;

  // Priority: clear, then load, then count, then hold.
  function automatic pcnt_op_e pick_op(input logic clr_act, input logic ld_act,
                                       input logic en_a, input logic en_b);
    if (clr_act)          return OP_CLEAR;
    else if (ld_act)      return OP_LOAD;
    else if (en_a && en_b) return OP_COUNT;
    else                  return OP_HOLD;
  endfunction

endpackage

// File: rtl/pcnt_ctrl.sv
module pcnt_ctrl
  import pcnt_pkg::*;
(
  input  logic     clear_n,
  input  logic     load_n,
  input  logic     step_en,
  input  logic     chain_en,
  output pcnt_op_e op,
  output logic     ev_clear,
  output logic     ev_load,
  output logic     ev_count,
  output logic     ev_hold
);

  always_comb begin
    op       = pick_op(!clear_n, !load_n, step_en, chain_en);
    ev_clear = (op == OP_CLEAR);
    ev_load  = (op == OP_LOAD);
    ev_count = (op == OP_COUNT);
    ev_hold  = (op == OP_HOLD);
  end

endmodule

// File: rtl/pcnt_next.sv
module pcnt_next
  import pcnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  pcnt_op_e         op,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] par_d,
  output logic [WIDTH-1:0] nxt
);

  localparam logic [WIDTH-1:0] ZERO = '0;
  localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};

  // Modular increment; the all-ones value wraps to zero.
  function automatic logic [WIDTH-1:0] bump(input logic [WIDTH-1:0] v);
    return v + ONE;
  endfunction

  always_comb begin
    unique case (op)
      OP_CLEAR: nxt = ZERO;
      OP_LOAD:  nxt = par_d;
      OP_COUNT: nxt = bump(cur);
      default:  nxt = cur;
    endcase
  end

endmodule

// File: rtl/pcnt_state.sv
module pcnt_state #(
  parameter int WIDTH       = 4,
  parameter bit ASYNC_CLEAR = 1'b1
) (
  input  logic             clk,
  input  logic             clear_n,
  input  logic [WIDTH-1:0] nxt,
  output logic [WIDTH-1:0] q
);

  generate
    if (ASYNC_CLEAR) begin : g_async
      always_ff @(posedge clk or negedge clear_n) begin
        if (!clear_n) q <= '0;
        else          q <= nxt;
      end
    end else begin : g_sync
      // The clear is already folded into nxt by the priority decode.
      always_ff @(posedge clk) begin
        q <= nxt;
      end
    end
  endgenerate

endmodule

// File: rtl/pcnt_carry.sv
module pcnt_carry #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  input  logic             chain_en,
  input  logic             clear_n,
  output logic             at_top,
  output logic             carry_out
);

  function automatic logic is_top(input logic [WIDTH-1:0] v);
    return &v;
  endfunction

  always_comb begin
    at_top    = is_top(q);
    carry_out = at_top && chain_en && clear_n;
  end

endmodule

// File: rtl/presettable_counter.sv
module presettable_counter
  import pcnt_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter bit ASYNC_CLEAR = 1'b1
) (
  input  logic             clk,
  input  logic             clear_n,
  input  logic             load_n,
  input  logic [WIDTH-1:0] par_d,
  input  logic             step_en,
  input  logic             chain_en,
  output logic [WIDTH-1:0] q,
  output logic             carry_out
);

  pcnt_op_e         op;
  logic             ev_clear;
  logic             ev_load;
  logic             ev_count;
  logic             ev_hold;
  logic             at_top;
  logic [WIDTH-1:0] nxt;

  pcnt_ctrl u_ctrl (
    .clear_n  (clear_n),
    .load_n   (load_n),
    .step_en  (step_en),
    .chain_en (chain_en),
    .op       (op),
    .ev_clear (ev_clear),
    .ev_load  (ev_load),
    .ev_count (ev_count),
    .ev_hold  (ev_hold)
  );

  pcnt_next #(.WIDTH(WIDTH)) u_next (
    .op    (op),
    .cur   (q),
    .par_d (par_d),
    .nxt   (nxt)
  );

  pcnt_state #(.WIDTH(WIDTH), .ASYNC_CLEAR(ASYNC_CLEAR)) u_state (
    .clk     (clk),
    .clear_n (clear_n),
    .nxt     (nxt),
    .q       (q)
  );

  pcnt_carry #(.WIDTH(WIDTH)) u_carry (
    .q         (q),
    .chain_en  (chain_en),
    .clear_n   (clear_n),
    .at_top    (at_top),
    .carry_out (carry_out)
  );

endmodule

// File: rtl/pcnt_checker.sv
module pcnt_checker #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             clear_n,
  input logic [WIDTH-1:0] par_d,
  input logic             step_en,
  input logic             chain_en,
  input logic [WIDTH-1:0] q,
  input logic             carry_out,
  input logic             ev_clear,
  input logic             ev_load,
  input logic             ev_count,
  input logic             ev_hold,
  input logic             at_top
);

  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!clear_n)
    ev_load |=> q == $past(par_d)); // R3

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!clear_n)
    ev_count |=> q == $past(q) + ONE); // R1

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!clear_n)
    ev_hold |=> $stable(q)); // R4

  AST_CARRY_NEEDS_CHAIN: assert property (@(posedge clk) disable iff (!clear_n)
    carry_out |-> (chain_en && at_top)); // R8

  AST_CARRY_AT_TOP: assert property (@(posedge clk) disable iff (!clear_n)
    (chain_en && (&q)) |-> carry_out); // R8

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!clear_n)
    $onehot({ev_clear, ev_load, ev_count, ev_hold}) && !ev_clear); // R7

  AST_STEP_NO_CARRY_EFFECT: assert property (@(posedge clk) disable iff (!clear_n)
    (chain_en && at_top && !step_en) |-> carry_out); // R8

endmodule

bind presettable_counter pcnt_checker #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .clear_n   (clear_n),
  .par_d     (par_d),
  .step_en   (step_en),
  .chain_en  (chain_en),
  .q         (q),
  .carry_out (carry_out),
  .ev_clear  (ev_clear),
  .ev_load   (ev_load),
  .ev_count  (ev_count),
  .ev_hold   (ev_hold),
  .at_top    (at_top)
);

// File: tb/tb_presettable_counter.sv
`timescale 1ns/1ps
module tb_presettable_counter;

  logic       clk = 1'b0;
  logic       clear_n = 1'b0;
  logic       load_n = 1'b1;
  logic [3:0] d_lo = 4'h0;
  logic [3:0] d_hi = 4'h0;
  logic       step_en = 1'b0;
  logic       chain_en = 1'b0;

  logic [3:0] a_lo, a_hi, s_lo, s_hi;
  logic       a_cl, a_ch, s_cl, s_ch;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  // Asynchronous-clear pair
  presettable_counter #(.WIDTH(4), .ASYNC_CLEAR(1'b1)) dut (
    .clk(clk), .clear_n(clear_n), .load_n(load_n), .par_d(d_lo),
    .step_en(step_en), .chain_en(chain_en), .q(a_lo), .carry_out(a_cl));
  presettable_counter #(.WIDTH(4), .ASYNC_CLEAR(1'b1)) dut_hi (
    .clk(clk), .clear_n(clear_n), .load_n(load_n), .par_d(d_hi),
    .step_en(step_en), .chain_en(a_cl), .q(a_hi), .carry_out(a_ch));
  // Synchronous-clear pair
  presettable_counter #(.WIDTH(4), .ASYNC_CLEAR(1'b0)) sdut (
    .clk(clk), .clear_n(clear_n), .load_n(load_n), .par_d(d_lo),
    .step_en(step_en), .chain_en(chain_en), .q(s_lo), .carry_out(s_cl));
  presettable_counter #(.WIDTH(4), .ASYNC_CLEAR(1'b0)) sdut_hi (
    .clk(clk), .clear_n(clear_n), .load_n(load_n), .par_d(d_hi),
    .step_en(step_en), .chain_en(s_cl), .q(s_hi), .carry_out(s_ch));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Sample 1 ns after the rising edge.
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk_both_lo(input string req, input int exp);
    chk({req, " async"}, a_lo, exp);
    chk({req, " sync"}, s_lo, exp);
  endtask

  task automatic t_reset();
    clear_n = 1'b0; load_n = 1'b1; step_en = 1'b1; chain_en = 1'b1;
    tick(); tick();
    chk_both_lo("R6 reset lo", 0);
    chk("R6 reset hi async", a_hi, 0);
    chk("R6 reset hi sync", s_hi, 0);
    chk("R8 carry low in clear", a_cl | s_cl, 0);
  endtask

  task automatic t_load_ignores_enables();
    clear_n = 1'b1; load_n = 1'b0; step_en = 1'b0; chain_en = 1'b0;
    d_lo = 4'hC; d_hi = 4'h3;
    tick();
    chk_both_lo("R3 load with enables low", 12);
    chk("R3 load hi async", a_hi, 3);
    chk("R3 load hi sync", s_hi, 3);
  endtask

  task automatic t_count_wrap();
    int exp_lo[6] = '{13, 14, 15, 0, 1, 2};
    load_n = 1'b1; step_en = 1'b1; chain_en = 1'b1;
    for (int i = 0; i < 6; i++) begin
      tick();
      chk_both_lo("R1 count step", exp_lo[i]);
      if (exp_lo[i] == 15) begin
        chk("R8 carry at top async", a_cl, 1);
        chk("R8 carry at top sync", s_cl, 1);
      end
      if (exp_lo[i] == 0) begin
        chk("R2 wrap carry drop async", a_cl, 0);
        chk("R9 hi stage stepped on wrap async", a_hi, 4);
        chk("R9 hi stage stepped on wrap sync", s_hi, 4);
      end
    end
    // inhibit: count held
    step_en = 1'b0;
    tick(); tick();
    chk_both_lo("R4 inhibit hold", 2);
  endtask

  task automatic t_hold_carry();
    load_n = 1'b0; d_lo = 4'hF; d_hi = 4'h1;
    tick();
    load_n = 1'b1; step_en = 1'b0; chain_en = 1'b1;
    tick();
    chk_both_lo("R4 hold step_en low", 15);
    chk("R8 carry with step_en low", a_cl, 1);
    chk("R8 carry with step_en low sync", s_cl, 1);
    step_en = 1'b1; chain_en = 1'b0;
    tick();
    chk_both_lo("R4 hold chain_en low", 15);
    chk("R8 carry gated by chain_en", a_cl | s_cl, 0);
  endtask

  task automatic t_load_over_count();
    step_en = 1'b1; chain_en = 1'b1; load_n = 1'b0; d_lo = 4'h5;
    tick();
    chk_both_lo("R10 load beats count", 5);
    load_n = 1'b1;
  endtask

  task automatic t_clear_over_load();
    load_n = 1'b0; d_lo = 4'hA; clear_n = 1'b0;
    tick();
    chk_both_lo("R7 clear beats load", 0);
    clear_n = 1'b1; load_n = 1'b1;
  endtask

  task automatic t_clear_timing();
    load_n = 1'b0; d_lo = 4'h9;
    tick();
    load_n = 1'b1; step_en = 1'b0;
    @(negedge clk);
    clear_n = 1'b0;
    #1;
    chk("R5 async clear immediate", a_lo, 0);
    chk("R6 sync clear waits for edge", s_lo, 9);
    tick();
    chk("R6 sync clear at edge", s_lo, 0);
    clear_n = 1'b1;
  endtask

  task automatic t_cascade();
    int ref8;
    load_n = 1'b0; d_lo = 4'h0; d_hi = 4'h0; step_en = 1'b1; chain_en = 1'b1;
    tick();
    load_n = 1'b1;
    ref8 = 0;
    for (int i = 0; i < 262; i++) begin
      tick();
      ref8 = (ref8 + 1) % 256;
      chk("R9 cascade async", {a_hi, a_lo}, ref8);
      chk("R9 cascade sync", {s_hi, s_lo}, ref8);
      if (ref8 == 255) chk("R9 hi carry at 255", a_ch & s_ch, 1);
      if (ref8 == 0)   chk("R9 hi carry drops at wrap", a_ch | s_ch, 0);
    end
  endtask

  initial begin
    fork
      begin
        #1;
        t_reset();
        t_load_ignores_enables();
        t_count_wrap();
        t_hold_carry();
        t_load_over_count();
        t_clear_over_load();
        t_clear_timing();
        t_cascade();
        done = 1'b1;
      end
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          total++; bad++;
          $display("FAIL watchdog: actual=hung expected=finished");
        end
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule